// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block produces periodic refresh demands for a DRAM array. It runs only from the host clock and takes no input from any expansion bus. A down-counter marks out one refresh interval. In single mode each interval adds one refresh to a pending count. In burst mode the block adds a batch of four refreshes once every four intervals. The timer keeps reloading, so refreshes that are still pending never slow the average rate.

Pending refreshes wait while the memory interface is busy and are offered to the refresh sequencer once it goes idle. If the backlog grows to a forced level, a high-priority flag is raised and the request is offered even while the interface is busy. The arbiter then grants it at the next transaction boundary, so no open row is held past its maximum active time. Each acknowledged refresh takes one from the count, and the count saturates at a parameter maximum.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is low at a clock edge, the pending count, the request and the force flag all become zero.
- R2: In single mode (`burst_mode` = 0), the pending count grows by exactly one every `INTERVAL` host clocks when there are no acknowledges.
- R3: In burst mode (`burst_mode` = 1), the pending count grows by exactly four once every 4×`INTERVAL` host clocks and does not grow at any other time.
- R4: The mode bit is sampled at each interval end. A change between modes takes effect from the next interval end without restarting the timer.
- R5: When the pending count is non-zero and below `FORCE_LVL`, `rfsh_req` follows `dram_idle`: it is high when the interface is idle and low while it is busy.
- R6: `rfsh_force` is high exactly when the pending count is at or above `FORCE_LVL`. While it is high, `rfsh_req` is high whatever `dram_idle` says.
- R7: An acknowledge lowers the pending count by one. An acknowledge while the count is zero has no effect.
- R8: The pending count never exceeds `PEND_MAX`. Growth beyond it is dropped.
- R9: The interval timer runs without pause through resets of nothing but itself. Acknowledges, idle state and the pending level never shift when an interval ends. When an acknowledge and an interval end fall in the same cycle, both apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_mode | input | 1 | Control bit: 0 selects one refresh per interval, 1 selects four per four intervals |
| dram_idle | input | 1 | High when the DRAM interface has no transaction in progress |
| rfsh_ack | input | 1 | One refresh has been carried out by the sequencer |
| rfsh_req | output | 1 | Request to the refresh sequencer |
| rfsh_force | output | 1 | High-priority flag: the backlog has reached the forced level |
| rfsh_pend | output | $clog2(PEND_MAX+1) | Number of refreshes still owed |

## Verification
On every cycle the embedded assertions check the timer's countdown and reload, the limit on the pending count, the one-step decrement and the ignored acknowledge at zero, and how request and force relate to the idle input. The long-term cadence can only be seen by the bench's cycle model over whole intervals: one refresh per interval against four per four intervals. The same holds for a mode change partway through a batch period and for an acknowledge that lands on an interval end while other traffic is running.

// File: rtl/rfsh_pkg.sv
// Shared constants and types for the refresh request scheduler.
// Assumes nothing beyond standard SystemVerilog.
package rfsh_pkg;
    // number of refreshes owed per batch in burst mode
    localparam int unsigned BURST_LEN = 4;
    // width of the per-cycle increment carried from timer to counter
    localparam int unsigned ADD_W = 3;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_BURST  = 1'b1
    } rfsh_mode_e;
endpackage

// File: rtl/rfsh_tick_gen.sv
// Interval timer. Counts host clocks down from INTERVAL-1 and reloads at
// zero. A two-bit interval counter groups intervals into batches of four.
// Each cycle it reports how many refreshes become owed: 0 between interval
// ends, 1 at each end in single mode, 4 at every fourth end in burst mode.
// Assumes INTERVAL >= 2 and a mode bit that is quasi-static.
module rfsh_tick_gen
    import rfsh_pkg::*;
#(
    parameter int unsigned INTERVAL = 1040
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rfsh_mode_e       mode,
    output logic [ADD_W-1:0] add_amt
);
    localparam int unsigned CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;
    logic [1:0]    qtr_q;
    logic          tick;

    assign tick = (cnt_q == '0);

    // countdown with reload at terminal count; never paused by pending work
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (tick) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // interval index within a batch of four
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qtr_q <= '0;
        end else if (tick) begin
            qtr_q <= qtr_q + 1'b1;
        end
    end

    // refreshes owed this cycle, chosen by the mode bit at the interval end
    always_comb begin
        add_amt = '0;
        if (tick) begin
            if (mode == MODE_BURST) begin
                add_amt = (qtr_q == 2'd3) ? ADD_W'(BURST_LEN) : '0;
            end else begin
                add_amt = ADD_W'(1);
            end
        end
    end

    // R9: the timer reloads right after terminal count
    p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == RELOAD));

    // R2: between interval ends the timer steps down by exactly one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R3: burst mode never owes anything other than zero or a full batch
    p_batch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BURST) |-> (add_amt == '0 || add_amt == ADD_W'(BURST_LEN)));
endmodule

// File: rtl/rfsh_pend_ctr.sv
// Pending-refresh counter. Adds what the timer reports, subtracts one per
// acknowledge (only when non-zero) and clips the result at PEND_MAX.
// Assumes the acknowledge is a one-cycle pulse per completed refresh.
module rfsh_pend_ctr
    import rfsh_pkg::*;
#(
    parameter int unsigned PEND_MAX = 8,
    parameter int unsigned PW       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADD_W-1:0] add_amt,
    input  logic             ack,
    output logic [PW-1:0]    pend
);
    localparam int unsigned SW = PW + ADD_W;
    localparam logic [SW-1:0] CAP = SW'(PEND_MAX);

    logic [PW-1:0] pend_q;
    logic          dec;
    logic [SW-1:0] sum;

    assign dec = ack && (pend_q != '0);

    // next level before clipping
    always_comb begin
        sum = SW'(pend_q) + SW'(add_amt) - SW'(dec);
    end

    // register the clipped level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (sum > CAP) begin
            pend_q <= PW'(PEND_MAX);
        end else begin
            pend_q <= PW'(sum);
        end
    end

    assign pend = pend_q;

    // R8: the count stays within its limit
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        SW'(pend_q) <= CAP);

    // R7: an acknowledge at zero with nothing added leaves zero
    p_ack_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0 && ack && add_amt == '0) |=> (pend_q == '0));

    // R7: an acknowledge on a non-zero count removes exactly one
    p_ack_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0 && ack && add_amt == '0) |=> (pend_q == $past(pend_q) - 1'b1));
endmodule

// File: rtl/rfsh_sched.sv
// Refresh request scheduler top. Joins the interval timer and the pending
// counter, and decides when the owed refreshes are offered: on idle
// normally, at once when the backlog reaches FORCE_LVL.
// Assumes 1 <= FORCE_LVL <= PEND_MAX and a downstream arbiter that grants a
// forced request at its next transaction boundary.
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int unsigned INTERVAL  = 1040,
    parameter int unsigned PEND_MAX  = 8,
    parameter int unsigned FORCE_LVL = 4,
    localparam int unsigned PW = $clog2(PEND_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst_mode,
    input  logic          dram_idle,
    input  logic          rfsh_ack,
    output logic          rfsh_req,
    output logic          rfsh_force,
    output logic [PW-1:0] rfsh_pend
);
    logic [ADD_W-1:0] add_amt;
    logic [PW-1:0]    pend;
    rfsh_mode_e       mode;

    assign mode = burst_mode ? MODE_BURST : MODE_SINGLE;

    rfsh_tick_gen #(.INTERVAL(INTERVAL)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .add_amt (add_amt)
    );

    rfsh_pend_ctr #(.PEND_MAX(PEND_MAX), .PW(PW)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_amt (add_amt),
        .ack     (rfsh_ack),
        .pend    (pend)
    );

    // offer owed refreshes on idle, or regardless once the backlog is deep
    always_comb begin
        rfsh_force = (pend >= PW'(FORCE_LVL));
        rfsh_req   = (pend != '0) && (dram_idle || rfsh_force);
    end

    assign rfsh_pend = pend;

    // R6: a forced backlog is always offered
    p_force_offers_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_force |-> rfsh_req);

    // R5: below the forced level a busy interface sees no request
    p_busy_defers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_idle && !rfsh_force) |-> !rfsh_req);

    // R5: nothing owed means nothing requested
    p_empty_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_pend == '0) |-> !rfsh_req);
endmodule

// File: tb/rfsh_sched_bench.sv
module rfsh_sched_bench;
    localparam int INTERVAL  = 16;
    localparam int PEND_MAX  = 7;
    localparam int FORCE_LVL = 4;
    localparam int PW        = $clog2(PEND_MAX + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          burst_mode = 1'b0;
    logic          dram_idle = 1'b0;
    logic          rfsh_ack = 1'b0;
    logic          rfsh_req;
    logic          rfsh_force;
    logic [PW-1:0] rfsh_pend;

    always #4 clk = ~clk;

    rfsh_sched #(.INTERVAL(INTERVAL), .PEND_MAX(PEND_MAX), .FORCE_LVL(FORCE_LVL)) u_rfsh_sched (
        .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .dram_idle(dram_idle),
        .rfsh_ack(rfsh_ack), .rfsh_req(rfsh_req), .rfsh_force(rfsh_force), .rfsh_pend(rfsh_pend)
    );

    // behavioural reference: elapsed clocks within an interval, intervals mod 4, owed count
    int m_phase = 0;
    int m_ivl = 0;
    int m_pend = 0;
    int chk_a = 0, fail_a = 0;
    int chk_b = 0, fail_b = 0;
    bit done = 0;

    always @(posedge clk) begin
        int add;
        bit ack_s, idle_s, burst_s, rst_s;
        ack_s = rfsh_ack; idle_s = dram_idle; burst_s = burst_mode; rst_s = rst_n;
        if (!rst_s) begin
            m_phase = 0; m_ivl = 0; m_pend = 0;
        end else begin
            add = 0;
            if (m_phase == INTERVAL - 1) begin
                if (burst_s) add = (m_ivl == 3) ? 4 : 0;
                else         add = 1;
                m_phase = 0;
                m_ivl = (m_ivl + 1) % 4;
            end else begin
                m_phase++;
            end
            m_pend = m_pend + add - ((ack_s && m_pend > 0) ? 1 : 0);
            if (m_pend > PEND_MAX) m_pend = PEND_MAX;
        end
        #2;
        if (rst_s && !done) begin
            bit e_force, e_req;
            e_force = (m_pend >= FORCE_LVL);
            e_req   = (m_pend > 0) && (dram_idle || e_force);
            chk_a += 3;
            if (rfsh_pend !== PW'(m_pend)) begin
                fail_a++;
                $display("FAIL R2/R3/R7/R8/R9 pend: actual %0d expected %0d at %0t", rfsh_pend, m_pend, $time);
            end
            if (rfsh_force !== e_force) begin
                fail_a++;
                $display("FAIL R6 force: actual %0b expected %0b at %0t", rfsh_force, e_force, $time);
            end
            if (rfsh_req !== e_req) begin
                fail_a++;
                $display("FAIL R5 req: actual %0b expected %0b at %0t", rfsh_req, e_req, $time);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        chk_b++;
        if (act != exp) begin
            fail_b++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        dram_idle = 1'b1;
        while (rfsh_pend != 0) begin
            rfsh_ack = 1'b1; cyc(1);
        end
        rfsh_ack = 1'b0;
        dram_idle = 1'b0;
    endtask

    task automatic finish_run();
        int tot, bad;
        if (!done) begin
            done = 1;
            tot = chk_a + chk_b;
            bad = fail_a + fail_b;
            $display("%0d/%0d checks passed", tot - bad, tot);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        chk_b++; fail_b++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int p0;
        bit [15:0] lfsr;
        cyc(4);
        // R1: reset state
        chk("R1 pend", int'(rfsh_pend), 0);
        chk("R1 req", int'(rfsh_req), 0);
        chk("R1 force", int'(rfsh_force), 0);
        rst_n = 1'b1;

        // R5: busy, three intervals owed, nothing requested
        cyc(3 * INTERVAL);
        chk("R2 pend after three intervals", int'(rfsh_pend), 3);
        chk("R5 busy withholds", int'(rfsh_req), 0);
        dram_idle = 1'b1; #1;
        chk("R5 idle offers", int'(rfsh_req), 1);
        dram_idle = 1'b0;

        // R6: fourth interval reaches forced level
        cyc(INTERVAL);
        chk("R6 force at level", int'(rfsh_force), 1);
        chk("R6 req while busy", int'(rfsh_req), 1);

        // R7: acknowledges at zero change nothing
        drain();
        dram_idle = 1'b1; rfsh_ack = 1'b1; cyc(3);
        rfsh_ack = 1'b0; dram_idle = 1'b0;
        chk("R7 ack at zero ignored", int'(rfsh_pend), 0);

        // R8: saturation under a long busy stretch
        cyc(12 * INTERVAL);
        chk("R8 saturates", int'(rfsh_pend), PEND_MAX);

        // R2: single mode adds one over exactly one interval
        drain();
        p0 = int'(rfsh_pend);
        cyc(INTERVAL);
        chk("R2 one per interval", int'(rfsh_pend), p0 + 1);

        // R3/R4: burst mode adds four over a batch period
        burst_mode = 1'b1;
        drain();
        p0 = int'(rfsh_pend);
        cyc(4 * INTERVAL);
        chk("R3 four per batch", int'(rfsh_pend), p0 + 4);
        burst_mode = 1'b0;
        drain();
        p0 = int'(rfsh_pend);
        cyc(2 * INTERVAL);
        chk("R4 back to single", int'(rfsh_pend), p0 + 2);

        // R9: mixed traffic, acknowledges landing on interval ends
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            dram_idle = lfsr[0];
            rfsh_ack  = lfsr[1] & lfsr[2];
            if (lfsr[9:3] == 7'd0) burst_mode = ~burst_mode;
            cyc(1);
        end
        rfsh_ack = 1'b0;
        cyc(2);
        finish_run();
    end
endmodule